// File: doc/BRIEF.md
# Host Parallel Port to DSP Internal-Memory Bridge

This block sits on the peripheral side of an enhanced host parallel port. It lets the host reach the internal memory of a 16-bit DSP through that DSP's direct-memory port. The host works in 8-bit cycles of four kinds: address write, address read, data write and data read. Each cycle is closed by an interlocked strobe/acknowledge handshake, so a transfer runs at the pace of the slower of the two sides.

Address-write bytes build a 16-bit start word, low byte first. The top bit selects the DSP memory space. When the second byte arrives, the bridge issues one address-latch phase on the DSP's multiplexed bus. Data bytes are paired into 16-bit words, low byte first. A pair of host data writes becomes one DSP write. The first of two host data reads starts one DSP read and returns the low half. The second returns the held high half. The DSP advances its own transfer address after every access, so no latch phase is issued per word.

All inputs are taken as synchronous to `clk`. Both buses are split into input, output and output-enable, so the pads can be built outside the block.

Top module: `epp_dsp_bridge`

## Requirements
- R1: After `rst_n` is low at a clock edge, or after `h_init_n` is low at a clock edge, the outputs return to idle: `h_ack_n`=1, `h_ad_oe`=0, `d_sel_n`=1, `d_rd_n`=1, `d_wr_n`=1, `d_latch`=0, `d_ad_oe`=0.
- R2: A host cycle starts when exactly one of `h_dstb_n` (data) or `h_astb_n` (address) is low. `h_write_n`=0 marks a write and 1 marks a read. The bridge answers by driving `h_ack_n` low. `h_ack_n` stays low while either strobe is low, and returns high once both strobes are high.
- R3: `h_ad_oe` is 1 only while `h_ack_n` is low in a host read cycle. During a write cycle it stays 0.
- R4: The first host address write stores the low byte and causes no DSP access. The second stores the high byte and issues one latch phase: `d_sel_n`=0, `d_latch`=1, `d_rd_n`=`d_wr_n`=1, and `d_ad_o`={high, low} driven with `d_ad_oe`=1.
- R5: Host address reads return the stored start word, alternating low byte then high byte, starting with the low byte.
- R6: The first host data write of a pair stores the low byte and causes no DSP access. The second starts one DSP write of {high, low}, with `d_wr_n`=0, `d_rd_n`=1, `d_latch`=0 and `d_ad_oe`=1.
- R7: The first host data read of a pair starts one DSP read (`d_rd_n`=0, `d_wr_n`=1, `d_latch`=0, `d_ad_oe`=0) and returns bits 7:0 of the word read. The second returns bits 15:8 of that same word and makes no DSP access.
- R8: DSP strobes stay asserted until `d_ack_n` is seen low. A new DSP access starts only while `d_ack_n` is high. The host acknowledge of a cycle that started a DSP access falls only after that access has been acknowledged and its strobes released.
- R9: Successive data words cause no further latch phases. They land at successive DSP addresses through the DSP's own increment.
- R10: Completing an address-write pair discards any half-filled data word and restarts both the data byte order and the address-read order at the low byte.
- R11: `h_init_n` low discards a half-filled data word. The next two data writes form a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_write_n | input | 1 | Host direction: 0 write, 1 read |
| h_dstb_n | input | 1 | Host data strobe, active low |
| h_astb_n | input | 1 | Host address strobe, active low |
| h_init_n | input | 1 | Host initialise, active low, returns the bridge to idle |
| h_ad_i | input | 8 | Host bus, value driven by the host |
| h_ad_o | output | 8 | Host bus, value driven by the bridge |
| h_ad_oe | output | 1 | Host bus output enable |
| h_ack_n | output | 1 | Host acknowledge (wait), active low |
| d_ad_i | input | 16 | DSP bus, value driven by the DSP |
| d_ad_o | output | 16 | DSP bus, value driven by the bridge |
| d_ad_oe | output | 1 | DSP bus output enable |
| d_sel_n | output | 1 | DSP port select, active low |
| d_rd_n | output | 1 | DSP read enable, active low |
| d_wr_n | output | 1 | DSP write enable, active low |
| d_latch | output | 1 | DSP address-latch enable, active high |
| d_ack_n | input | 1 | DSP acknowledge, active low |

## Verification
The assertions watch the pin rules of both buses on every cycle:
- read and write enables are never low together;
- the latch enable is low during data strobes;
- no strobe is asserted without the select;
- the bridge does not drive the DSP bus during a read;
- the host bus is driven only in an acknowledged read;
- DSP strobes are held until acknowledged;
- the host acknowledge is held while a strobe is low and never falls during a DSP access.

Only the bench scenarios can show the data path: byte order, word values, address increment across words, address read-back, and the effect of a new start address or an init pulse on a half-filled word. They also show the interlock with a slow DSP acknowledge.

// File: rtl/epp_dsp_pkg.sv
// Package: shared cycle and operation codes for the parallel-port to DSP bridge.
// Assumes nothing beyond being compiled before the modules that import it.
package epp_dsp_pkg;

    // Kind of host cycle decoded from strobe and direction lines
    typedef enum logic [1:0] {
        HC_DATA_WR = 2'd0,
        HC_DATA_RD = 2'd1,
        HC_ADDR_WR = 2'd2,
        HC_ADDR_RD = 2'd3
    } host_cyc_e;

    // Kind of access issued on the DSP side
    typedef enum logic [1:0] {
        DOP_LATCH = 2'd0,
        DOP_WRITE = 2'd1,
        DOP_READ  = 2'd2
    } dsp_op_e;

endpackage

// File: rtl/epp_host_port.sv
// Module: host-side handshake engine.
// Decodes a host cycle when exactly one strobe is low, hands it to the packer
// as a one-cycle start pulse, waits for the packer's done pulse, then pulls the
// acknowledge low (driving the bus on reads) until both strobes are released.
// Assumes host lines are synchronous to clk and stable while a strobe is low.
module epp_host_port
    import epp_dsp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              h_write_n,
    input  logic              h_dstb_n,
    input  logic              h_astb_n,
    input  logic [BYTE_W-1:0] h_ad_i,
    output logic [BYTE_W-1:0] h_ad_o,
    output logic              h_ad_oe,
    output logic              h_ack_n,
    output logic              cyc_start,
    output host_cyc_e         cyc_kind,
    output logic [BYTE_W-1:0] cyc_byte,
    input  logic              cyc_done,
    input  logic [BYTE_W-1:0] cyc_rbyte
);

    typedef enum logic [1:0] {HP_IDLE, HP_BUSY, HP_HOLD} hp_state_e;
    hp_state_e state;

    logic is_read;
    // Purpose: flag the latched cycle as a read so the bus is driven back
    always_comb is_read = (cyc_kind == HC_DATA_RD) || (cyc_kind == HC_ADDR_RD);

    // Purpose: run the interlocked strobe/acknowledge sequence
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            state     <= HP_IDLE;
            cyc_start <= 1'b0;
            cyc_kind  <= HC_DATA_WR;
            cyc_byte  <= '0;
            h_ad_o    <= '0;
            h_ad_oe   <= 1'b0;
            h_ack_n   <= 1'b1;
        end else begin
            cyc_start <= 1'b0;
            case (state)
                HP_IDLE: begin
                    if (h_dstb_n ^ h_astb_n) begin
                        if (!h_astb_n)
                            cyc_kind <= h_write_n ? HC_ADDR_RD : HC_ADDR_WR;
                        else
                            cyc_kind <= h_write_n ? HC_DATA_RD : HC_DATA_WR;
                        cyc_byte  <= h_ad_i;
                        cyc_start <= 1'b1;
                        state     <= HP_BUSY;
                    end
                end
                HP_BUSY: begin
                    if (cyc_done) begin
                        h_ack_n <= 1'b0;
                        h_ad_o  <= cyc_rbyte;
                        h_ad_oe <= is_read;
                        state   <= HP_HOLD;
                    end
                end
                default: begin
                    if (h_dstb_n && h_astb_n) begin
                        h_ack_n <= 1'b1;
                        h_ad_oe <= 1'b0;
                        state   <= HP_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/epp_word_packer.sv
// Module: byte/word packer and start-address holder.
// Keeps the start word built from host address writes, the low data byte
// waiting for its partner, and the high byte of the last DSP read. Decides
// per host cycle whether a DSP access is needed; answers with a done pulse.
// Assumes the host port issues at most one start until done is returned.
module epp_word_packer
    import epp_dsp_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              cyc_start,
    input  host_cyc_e         cyc_kind,
    input  logic [BYTE_W-1:0] cyc_byte,
    output logic              cyc_done,
    output logic [BYTE_W-1:0] cyc_rbyte,
    output logic              seq_start,
    output dsp_op_e           seq_op,
    output logic [WORD_W-1:0] seq_wdata,
    input  logic              seq_done,
    input  logic [WORD_W-1:0] seq_rdata
);

    logic [BYTE_W-1:0] addr_lo, addr_hi;   // stored start word halves
    logic [BYTE_W-1:0] data_lo;            // pending low data byte
    logic [BYTE_W-1:0] read_hi;            // held high byte of last DSP read
    logic              aw_hi;              // next address write is the high byte
    logic              ar_hi;              // next address read returns high byte
    logic              d_hi;               // next data cycle is the high byte

    // Purpose: route each host cycle to a stored byte or a DSP access
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            addr_lo   <= '0;
            addr_hi   <= '0;
            data_lo   <= '0;
            read_hi   <= '0;
            aw_hi     <= 1'b0;
            ar_hi     <= 1'b0;
            d_hi      <= 1'b0;
            cyc_done  <= 1'b0;
            cyc_rbyte <= '0;
            seq_start <= 1'b0;
            seq_op    <= DOP_LATCH;
            seq_wdata <= '0;
        end else begin
            cyc_done  <= 1'b0;
            seq_start <= 1'b0;
            if (cyc_start) begin
                case (cyc_kind)
                    HC_ADDR_WR: begin
                        if (!aw_hi) begin
                            addr_lo  <= cyc_byte;
                            aw_hi    <= 1'b1;
                            cyc_done <= 1'b1;
                        end else begin
                            addr_hi   <= cyc_byte;
                            aw_hi     <= 1'b0;
                            seq_start <= 1'b1;
                            seq_op    <= DOP_LATCH;
                            seq_wdata <= {cyc_byte, addr_lo};
                        end
                    end
                    HC_ADDR_RD: begin
                        cyc_rbyte <= ar_hi ? addr_hi : addr_lo;
                        ar_hi     <= ~ar_hi;
                        cyc_done  <= 1'b1;
                    end
                    HC_DATA_WR: begin
                        if (!d_hi) begin
                            data_lo  <= cyc_byte;
                            d_hi     <= 1'b1;
                            cyc_done <= 1'b1;
                        end else begin
                            d_hi      <= 1'b0;
                            seq_start <= 1'b1;
                            seq_op    <= DOP_WRITE;
                            seq_wdata <= {cyc_byte, data_lo};
                        end
                    end
                    default: begin
                        if (!d_hi) begin
                            seq_start <= 1'b1;
                            seq_op    <= DOP_READ;
                        end else begin
                            cyc_rbyte <= read_hi;
                            d_hi      <= 1'b0;
                            cyc_done  <= 1'b1;
                        end
                    end
                endcase
            end
            if (seq_done) begin
                cyc_done <= 1'b1;
                case (seq_op)
                    DOP_READ: begin
                        cyc_rbyte <= seq_rdata[BYTE_W-1:0];
                        read_hi   <= seq_rdata[WORD_W-1:BYTE_W];
                        d_hi      <= 1'b1;
                    end
                    DOP_LATCH: begin
                        d_hi  <= 1'b0;
                        ar_hi <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/epp_dsp_seq.sv
// Module: DSP-side access sequencer.
// On a start pulse it waits for the DSP acknowledge to be released, asserts
// select plus the strobe for the operation (latch, write or read), holds them
// until the acknowledge goes low, captures read data and returns a done pulse.
// Assumes the DSP releases its acknowledge after the select is removed.
module epp_dsp_seq
    import epp_dsp_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              seq_start,
    input  dsp_op_e           seq_op,
    input  logic [WORD_W-1:0] seq_wdata,
    output logic              seq_done,
    output logic [WORD_W-1:0] seq_rdata,
    input  logic [WORD_W-1:0] d_ad_i,
    output logic [WORD_W-1:0] d_ad_o,
    output logic              d_ad_oe,
    output logic              d_sel_n,
    output logic              d_rd_n,
    output logic              d_wr_n,
    output logic              d_latch,
    input  logic              d_ack_n
);

    typedef enum logic [1:0] {DS_IDLE, DS_ARM, DS_RUN} ds_state_e;
    ds_state_e state;

    // Purpose: sequence one acknowledged DSP access per start pulse
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            state     <= DS_IDLE;
            seq_done  <= 1'b0;
            seq_rdata <= '0;
            d_ad_o    <= '0;
            d_ad_oe   <= 1'b0;
            d_sel_n   <= 1'b1;
            d_rd_n    <= 1'b1;
            d_wr_n    <= 1'b1;
            d_latch   <= 1'b0;
        end else begin
            seq_done <= 1'b0;
            case (state)
                DS_IDLE: begin
                    if (seq_start) begin
                        d_ad_o <= seq_wdata;
                        state  <= DS_ARM;
                    end
                end
                DS_ARM: begin
                    if (d_ack_n) begin
                        d_sel_n <= 1'b0;
                        d_latch <= (seq_op == DOP_LATCH);
                        d_wr_n  <= (seq_op != DOP_WRITE);
                        d_rd_n  <= (seq_op != DOP_READ);
                        d_ad_oe <= (seq_op != DOP_READ);
                        state   <= DS_RUN;
                    end
                end
                default: begin
                    if (!d_ack_n) begin
                        seq_rdata <= d_ad_i;
                        d_sel_n   <= 1'b1;
                        d_latch   <= 1'b0;
                        d_wr_n    <= 1'b1;
                        d_rd_n    <= 1'b1;
                        d_ad_oe   <= 1'b0;
                        seq_done  <= 1'b1;
                        state     <= DS_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/epp_dsp_bridge.sv
// Module: top of the parallel-port to DSP direct-memory bridge.
// Joins the host handshake engine, the byte/word packer and the DSP access
// sequencer. Host init and reset both clear every register synchronously.
// Assumes all inputs are synchronous to clk; pads are built outside.
module epp_dsp_bridge
    import epp_dsp_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_write_n,
    input  logic              h_dstb_n,
    input  logic              h_astb_n,
    input  logic              h_init_n,
    input  logic [BYTE_W-1:0] h_ad_i,
    output logic [BYTE_W-1:0] h_ad_o,
    output logic              h_ad_oe,
    output logic              h_ack_n,
    input  logic [WORD_W-1:0] d_ad_i,
    output logic [WORD_W-1:0] d_ad_o,
    output logic              d_ad_oe,
    output logic              d_sel_n,
    output logic              d_rd_n,
    output logic              d_wr_n,
    output logic              d_latch,
    input  logic              d_ack_n
);

    logic              clr_n;
    logic              cyc_start, cyc_done;
    host_cyc_e         cyc_kind;
    logic [BYTE_W-1:0] cyc_byte, cyc_rbyte;
    logic              seq_start, seq_done;
    dsp_op_e           seq_op;
    logic [WORD_W-1:0] seq_wdata, seq_rdata;

    // Purpose: merge chip reset and host init into one synchronous clear
    always_comb clr_n = rst_n & h_init_n;

    epp_host_port #(.BYTE_W(BYTE_W)) u_host (
        .clk(clk), .clr_n(clr_n),
        .h_write_n(h_write_n), .h_dstb_n(h_dstb_n), .h_astb_n(h_astb_n),
        .h_ad_i(h_ad_i), .h_ad_o(h_ad_o), .h_ad_oe(h_ad_oe), .h_ack_n(h_ack_n),
        .cyc_start(cyc_start), .cyc_kind(cyc_kind), .cyc_byte(cyc_byte),
        .cyc_done(cyc_done), .cyc_rbyte(cyc_rbyte)
    );

    epp_word_packer #(.BYTE_W(BYTE_W)) u_pack (
        .clk(clk), .clr_n(clr_n),
        .cyc_start(cyc_start), .cyc_kind(cyc_kind), .cyc_byte(cyc_byte),
        .cyc_done(cyc_done), .cyc_rbyte(cyc_rbyte),
        .seq_start(seq_start), .seq_op(seq_op), .seq_wdata(seq_wdata),
        .seq_done(seq_done), .seq_rdata(seq_rdata)
    );

    epp_dsp_seq #(.WORD_W(WORD_W)) u_seq (
        .clk(clk), .clr_n(clr_n),
        .seq_start(seq_start), .seq_op(seq_op), .seq_wdata(seq_wdata),
        .seq_done(seq_done), .seq_rdata(seq_rdata),
        .d_ad_i(d_ad_i), .d_ad_o(d_ad_o), .d_ad_oe(d_ad_oe),
        .d_sel_n(d_sel_n), .d_rd_n(d_rd_n), .d_wr_n(d_wr_n),
        .d_latch(d_latch), .d_ack_n(d_ack_n)
    );

endmodule

// File: rtl/epp_dsp_bridge_chk.sv
// Module: protocol checker for the bridge pins, bound to every bridge instance.
// Assumes the same synchronous clear as the bridge (reset or host init).
module epp_dsp_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic h_init_n,
    input logic h_write_n,
    input logic h_dstb_n,
    input logic h_astb_n,
    input logic h_ad_oe,
    input logic h_ack_n,
    input logic d_ad_oe,
    input logic d_sel_n,
    input logic d_rd_n,
    input logic d_wr_n,
    input logic d_latch,
    input logic d_ack_n
);

    // R6, R7: read and write enables never low together
    a_r7_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n || !h_init_n)
        !(!d_rd_n && !d_wr_n));

    // R6, R7: latch enable held low during data strobes
    a_r6_latch_low_in_data: assert property (@(posedge clk) disable iff (!rst_n || !h_init_n)
        (!d_rd_n || !d_wr_n) |-> !d_latch);

    // R4: every strobe is qualified by the port select
    a_r4_strobe_has_select: assert property (@(posedge clk) disable iff (!rst_n || !h_init_n)
        (!d_rd_n || !d_wr_n || d_latch) |-> !d_sel_n);

    // R7: the bridge never drives the DSP bus during a read
    a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n || !h_init_n)
        !d_rd_n |-> !d_ad_oe);

    // R3: host bus driven only in an acknowledged read cycle
    a_r3_host_drive_read_only: assert property (@(posedge clk) disable iff (!rst_n || !h_init_n)
        h_ad_oe |-> (!h_ack_n && h_write_n));

    // R2: acknowledge held while a strobe is still low
    a_r2_ack_held: assert property (@(posedge clk) disable iff (!rst_n || !h_init_n)
        (!h_ack_n && (!h_dstb_n || !h_astb_n)) |=> !h_ack_n);

    // R8: DSP select held until the DSP acknowledges
    a_r8_select_held: assert property (@(posedge clk) disable iff (!rst_n || !h_init_n)
        (!d_sel_n && d_ack_n) |=> !d_sel_n);

    // R8: host acknowledge never falls while a DSP access is in progress
    a_r8_no_ack_mid_access: assert property (@(posedge clk) disable iff (!rst_n || !h_init_n)
        $fell(h_ack_n) |-> d_sel_n);

endmodule

bind epp_dsp_bridge epp_dsp_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .h_init_n(h_init_n), .h_write_n(h_write_n),
    .h_dstb_n(h_dstb_n), .h_astb_n(h_astb_n), .h_ad_oe(h_ad_oe), .h_ack_n(h_ack_n),
    .d_ad_oe(d_ad_oe), .d_sel_n(d_sel_n), .d_rd_n(d_rd_n), .d_wr_n(d_wr_n),
    .d_latch(d_latch), .d_ack_n(d_ack_n)
);

// File: tb/epp_dsp_bridge_test.sv
`timescale 1ns/1ps
// Bench: host cycles driven by tasks, a behavioural DSP memory with
// adjustable acknowledge delay, and expected values computed from the
// requirements. Pin rules are compared on every clock.
module epp_dsp_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_write_n = 1'b1, h_dstb_n = 1'b1, h_astb_n = 1'b1, h_init_n = 1'b1;
    logic [7:0]  h_ad_i = '0;
    logic [7:0]  h_ad_o;
    logic        h_ad_oe, h_ack_n;
    logic [15:0] d_ad_i, d_ad_o;
    logic        d_ad_oe, d_sel_n, d_rd_n, d_wr_n, d_latch;
    logic        d_ack_n;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    epp_dsp_bridge uut (
        .clk(clk), .rst_n(rst_n), .h_write_n(h_write_n), .h_dstb_n(h_dstb_n),
        .h_astb_n(h_astb_n), .h_init_n(h_init_n), .h_ad_i(h_ad_i), .h_ad_o(h_ad_o),
        .h_ad_oe(h_ad_oe), .h_ack_n(h_ack_n), .d_ad_i(d_ad_i), .d_ad_o(d_ad_o),
        .d_ad_oe(d_ad_oe), .d_sel_n(d_sel_n), .d_rd_n(d_rd_n), .d_wr_n(d_wr_n),
        .d_latch(d_latch), .d_ack_n(d_ack_n)
    );

    // ---------------- behavioural DSP memory ----------------
    logic [15:0] mem [32];
    logic [15:0] dsp_addr;
    logic [15:0] rd_word;
    logic [15:0] last_latch;
    int          ack_dly = 0;
    int          dly_cnt;
    int          latch_cnt, wr_cnt, rd_cnt;

    assign d_ad_i = rd_word;

    function automatic int idx(input logic [15:0] a);
        return {27'd0, a[15], a[3:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            d_ack_n <= 1'b1; dly_cnt <= 0; dsp_addr <= '0; rd_word <= '0;
            last_latch <= '0; latch_cnt <= 0; wr_cnt <= 0; rd_cnt <= 0;
            for (int i = 0; i < 32; i++) mem[i] <= 16'h0000;
        end else if (!d_sel_n && (d_latch || !d_rd_n || !d_wr_n)) begin
            if (d_ack_n) begin
                if (dly_cnt >= ack_dly) begin
                    d_ack_n <= 1'b0;
                    dly_cnt <= 0;
                    if (d_latch) begin
                        dsp_addr <= d_ad_o; last_latch <= d_ad_o; latch_cnt <= latch_cnt + 1;
                    end else if (!d_wr_n) begin
                        mem[idx(dsp_addr)] <= d_ad_o; dsp_addr <= dsp_addr + 16'd1;
                        wr_cnt <= wr_cnt + 1;
                    end else begin
                        rd_word <= mem[idx(dsp_addr)]; dsp_addr <= dsp_addr + 16'd1;
                        rd_cnt <= rd_cnt + 1;
                    end
                end else begin
                    dly_cnt <= dly_cnt + 1;
                end
            end
        end else begin
            d_ack_n <= 1'b1;
            dly_cnt <= 0;
        end
    end

    // ---------------- check helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison of pin rules against the requirements
    always @(negedge clk) begin
        if (rst_n && h_init_n && !finished) begin
            if (!d_rd_n || !d_wr_n)
                check(d_latch == 1'b0, "R6 latch low in data access", d_latch, 0);
            if (h_ad_oe)
                check(!h_ack_n && h_write_n, "R3 host bus drive", h_ack_n, 0);
        end
    end

    // one host cycle; need_dsp says whether the requirements call for a DSP access
    task automatic hcyc(input bit is_addr, input bit is_wr, input logic [7:0] b,
                        input bit need_dsp, input string req, output logic [7:0] rb);
        int snap;
        int t;
        @(negedge clk);
        snap = latch_cnt + wr_cnt + rd_cnt;
        h_write_n = !is_wr;
        h_ad_i    = b;
        if (is_addr) h_astb_n = 1'b0; else h_dstb_n = 1'b0;
        t = 0;
        while (h_ack_n && t < 500) begin @(negedge clk); t++; end
        check(t < 500, {req, " ack timeout"}, t, 0);
        check((latch_cnt + wr_cnt + rd_cnt) == snap + (need_dsp ? 1 : 0),
              {req, " R8 DSP accesses before host ack"}, latch_cnt + wr_cnt + rd_cnt - snap,
              need_dsp ? 1 : 0);
        check(h_ad_oe == !is_wr, {req, " R3 bus enable"}, h_ad_oe, !is_wr);
        rb = h_ad_o;
        repeat (2) @(negedge clk);
        check(h_ack_n == 1'b0, {req, " R2 ack held"}, h_ack_n, 0);
        h_dstb_n = 1'b1; h_astb_n = 1'b1;
        t = 0;
        while (!h_ack_n && t < 10) begin @(negedge clk); t++; end
        check(h_ack_n == 1'b1 && h_ad_oe == 1'b0, {req, " R2 ack release"}, h_ack_n, 1);
    endtask

    task automatic check_idle(input string req);
        check(h_ack_n && !h_ad_oe && d_sel_n && d_rd_n && d_wr_n && !d_latch && !d_ad_oe,
              req, {h_ack_n, h_ad_oe, d_sel_n, d_rd_n, d_wr_n, d_latch, d_ad_oe}, 7'b1011100);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0] rb;
        repeat (3) @(negedge clk);
        check_idle("R1 reset idle");
        rst_n = 1'b1;

        // R4: start address 0x0005 via two address writes
        hcyc(1, 1, 8'h05, 0, "R4 addr lo", rb);
        check(latch_cnt == 0, "R4 no latch after low byte", latch_cnt, 0);
        hcyc(1, 1, 8'h00, 1, "R4 addr hi", rb);
        check(latch_cnt == 1 && last_latch == 16'h0005, "R4 latched word", last_latch, 16'h0005);

        // R5: address read-back low then high
        hcyc(1, 0, 8'h00, 0, "R5 addr rd lo", rb);
        check(rb == 8'h05, "R5 low byte", rb, 8'h05);
        hcyc(1, 0, 8'h00, 0, "R5 addr rd hi", rb);
        check(rb == 8'h00, "R5 high byte", rb, 8'h00);

        // R6: data write pair, R9: second word at next address, no latch
        hcyc(0, 1, 8'h34, 0, "R6 data lo", rb);
        check(wr_cnt == 0, "R6 no write after low byte", wr_cnt, 0);
        hcyc(0, 1, 8'h12, 1, "R6 data hi", rb);
        check(mem[5] == 16'h1234, "R6 word written", mem[5], 16'h1234);
        hcyc(0, 1, 8'hCD, 0, "R9 data lo", rb);
        hcyc(0, 1, 8'hAB, 1, "R9 data hi", rb);
        check(mem[6] == 16'hABCD && latch_cnt == 1, "R9 increment, no latch", mem[6], 16'hABCD);

        // R7 and R8: slow DSP acknowledge, reads back both words
        ack_dly = 7;
        hcyc(1, 1, 8'h05, 0, "R4 addr lo", rb);
        hcyc(1, 1, 8'h00, 1, "R4 addr hi", rb);
        hcyc(0, 0, 8'h00, 1, "R7 read lo", rb);
        check(rb == 8'h34, "R7 low half", rb, 8'h34);
        hcyc(0, 0, 8'h00, 0, "R7 read hi", rb);
        check(rb == 8'h12 && rd_cnt == 1, "R7 high half held", rb, 8'h12);
        hcyc(0, 0, 8'h00, 1, "R9 read lo", rb);
        check(rb == 8'hCD, "R9 next word low", rb, 8'hCD);
        hcyc(0, 0, 8'h00, 0, "R9 read hi", rb);
        check(rb == 8'hAB, "R9 next word high", rb, 8'hAB);
        ack_dly = 0;

        // R10: half word discarded by new start address in space 1
        hcyc(0, 1, 8'h77, 0, "R10 stray lo", rb);
        hcyc(1, 1, 8'h08, 0, "R10 addr lo", rb);
        hcyc(1, 1, 8'h80, 1, "R10 addr hi", rb);
        check(last_latch == 16'h8008, "R10 latched space word", last_latch, 16'h8008);
        hcyc(0, 1, 8'h22, 0, "R10 data lo", rb);
        hcyc(0, 1, 8'h11, 1, "R10 data hi", rb);
        check(mem[24] == 16'h1122, "R10 fresh word pairing", mem[24], 16'h1122);
        hcyc(1, 0, 8'h00, 0, "R10 addr rd", rb);
        check(rb == 8'h08, "R10 addr rd low", rb, 8'h08);
        hcyc(1, 1, 8'h09, 0, "R10 addr lo", rb);
        hcyc(1, 1, 8'h80, 1, "R10 addr hi", rb);
        hcyc(1, 0, 8'h00, 0, "R10 addr rd after pair", rb);
        check(rb == 8'h09, "R10 addr read order restart", rb, 8'h09);

        // R11 and R1: init discards a half word
        hcyc(0, 1, 8'h99, 0, "R11 stray lo", rb);
        @(negedge clk); h_init_n = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R1 init idle");
        h_init_n = 1'b1;
        hcyc(0, 1, 8'h44, 0, "R11 data lo", rb);
        hcyc(0, 1, 8'h33, 1, "R11 data hi", rb);
        check(mem[25] == 16'h3344, "R11 word after init", mem[25], 16'h3344);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule